// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Data Path

This block holds the storage array of a synchronous burst SRAM together with the data path around it. Each cycle it receives an address that has already been resolved, a select flag and the write-control inputs. The write-control inputs are an active-low global write, an active-low byte-write enable and four active-low lane enables. From these the block decides whether the cycle is a deselect, a read or a write, and it updates only the byte lanes that the write controls pick. Each lane is `LANE_W` bits wide, so a word is four lanes.

Read data comes back by one of two paths, chosen by a static mode input. In pipeline mode it passes through an output register that loads on the rising edge. In flow-through mode it comes straight from the array. A separate driver-enable output tells the pad ring when the data lanes should be driven. An asynchronous active-low output enable gates that output. The output enable can switch the drivers off at any moment, but it cannot turn them on when no read data is being presented. Address sequencing and power-down are handled by other blocks.

Top module: `sram_datapath`

## Requirements
- R1: While reset is asserted and after it is released, `drive_o` stays low until a read has been accepted.
- R2: With `pipe_mode_i` low (flow-through), the word at the address of a read accepted on edge k appears on `rdata_o` with `drive_o` high in the cycle that follows edge k.
- R3: With `pipe_mode_i` high (pipeline), the word of a read accepted on edge k appears on `rdata_o` with `drive_o` high only after edge k+1. `drive_o` stays low between edge k and edge k+1 when the cycle before edge k was not a read.
- R4: A selected cycle with `gw_ni` low writes all four lanes, whatever the values of `bwe_ni` and `be_ni`.
- R5: With `gw_ni` high and `bwe_ni` low, the block writes exactly the lanes i for which `be_ni[i]` is low. Lane i occupies bits `[i*LANE_W +: LANE_W]`, and the other lanes keep their contents.
- R6: A selected cycle counts as a read, and changes no stored data, in two cases: `gw_ni` and `bwe_ni` are both high, or `bwe_ni` is low while all `be_ni` bits are high.
- R7: `drive_o` is low while a selected write cycle is on the inputs. A write never causes `drive_o` to go high afterwards.
- R8: `drive_o` is low whenever `oe_ni` is high, with no clock edge needed. Lowering `oe_ni` raises `drive_o` only while read data is being presented.
- R9: A read accepted with `oe_ni` high still loads its data. If `oe_ni` is lowered while that data is being presented, the data is driven.
- R10: A write commits on the edge that accepts it, so a read of the same address in the very next cycle returns the new data.
- R11: After an edge that accepts a non-read cycle, `drive_o` goes low after that same edge in flow-through mode, and one edge later in pipeline mode.
- R12: Back-to-back reads deliver one word per clock, in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 selects the registered read path, 0 selects flow-through |
| sel_i | input | 1 | Cycle is selected; 0 gives a deselect cycle |
| addr_i | input | ADDR_W | Resolved word address |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| be_ni | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 4*LANE_W | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 4*LANE_W | Read data toward the pads |
| drive_o | output | 1 | Data driver enable |

## Verification
The bench builds the block with `LANE_W = 8` and `ADDR_W = 4`. With these values each lane is one byte, so merged words from partial writes can be read directly in hexadecimal. The sixteen-word array also stays small enough for the bench to keep a full reference copy. Both values of the mode input are exercised in the same run, which brings the one-cycle latency difference and the different release of the drivers after a deselect within reach of directed checks.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;
  localparam int unsigned NUM_LANES = 4;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Reference lane-write decode, used by the checker.
  function automatic logic [NUM_LANES-1:0] lane_wr_mask(
    input logic                 gw_n,
    input logic                 bw_n,
    input logic [NUM_LANES-1:0] be_n
  );
    if (!gw_n)      return '1;
    else if (!bw_n) return ~be_n;
    else            return '0;
  endfunction
endpackage

// File: rtl/sram_dp_decode.sv
module sram_dp_decode
  import sram_dp_pkg::*;
(
  input  logic                 sel_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] be_ni,
  output logic [NUM_LANES-1:0] lane_we_o,
  output cyc_e                 cyc_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_we_o[g] = sel_i & (~gw_ni | (~bwe_ni & ~be_ni[g]));
  end

  always_comb begin
    if (!sel_i)          cyc_o = CYC_IDLE;
    else if (|lane_we_o) cyc_o = CYC_WRITE;
    else                 cyc_o = CYC_READ;
  end
endmodule

// File: rtl/sram_dp_array.sv
module sram_dp_array
  import sram_dp_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DATA_W = NUM_LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_en_i,
  input  logic [NUM_LANES-1:0] lane_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rd_vld_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_en_i;
      if (rd_en_i) addr_q <= addr_i;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_q];
  end

  assign rd_vld_o = rd_vld_q;
endmodule

// File: rtl/sram_dp_outstage.sv
module sram_dp_outstage #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              arr_vld_i,
  input  logic              wr_cyc_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] q_data;
  logic              q_vld;
  logic              present;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_data <= '0;
      q_vld  <= 1'b0;
    end else begin
      q_vld <= arr_vld_i;
      if (arr_vld_i) q_data <= arr_data_i;
    end
  end

  always_comb begin
    if (pipe_mode_i) begin
      rdata_o = q_data;
      present = q_vld;
    end else begin
      rdata_o = arr_data_i;
      present = arr_vld_i;
    end
  end

  // Output enable and a pending write can only remove drive.
  assign drive_o = present & ~oe_ni & ~wr_cyc_i;
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_dp_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pipe_mode_i,
  input  logic                 sel_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] be_ni,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 oe_ni,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 drive_o
);
  logic [NUM_LANES-1:0] lane_we;
  cyc_e                 cyc;
  logic [DATA_W-1:0]    arr_data;
  logic                 arr_vld;

  sram_dp_decode u_decode (
    .sel_i    (sel_i),
    .gw_ni    (gw_ni),
    .bwe_ni   (bwe_ni),
    .be_ni    (be_ni),
    .lane_we_o(lane_we),
    .cyc_o    (cyc)
  );

  sram_dp_array #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_en_i  (cyc == CYC_READ),
    .lane_we_i(lane_we),
    .wdata_i  (wdata_i),
    .rdata_o  (arr_data),
    .rd_vld_o (arr_vld)
  );

  sram_dp_outstage #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pipe_mode_i(pipe_mode_i),
    .arr_data_i (arr_data),
    .arr_vld_i  (arr_vld),
    .wr_cyc_i   (cyc == CYC_WRITE),
    .oe_ni      (oe_ni),
    .rdata_o    (rdata_o),
    .drive_o    (drive_o)
  );
endmodule

// File: rtl/sram_datapath_chk.sv
module sram_datapath_chk
  import sram_dp_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pipe_mode_i,
  input logic                 sel_i,
  input logic                 gw_ni,
  input logic                 bwe_ni,
  input logic [NUM_LANES-1:0] be_ni,
  input logic                 oe_ni,
  input logic                 drive_o
);
  logic wr_now, rd_now;
  assign wr_now = sel_i && (lane_wr_mask(gw_ni, bwe_ni, be_ni) != '0);
  assign rd_now = sel_i && !wr_now;

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!drive_o);
  end

  assert_flow_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && rd_now) |=> (pipe_mode_i || oe_ni || wr_now || drive_o));

  assert_pipe_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && rd_now) ##1 pipe_mode_i |=> (oe_ni || wr_now || drive_o));

  assert_write_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_now |-> !drive_o);

  assert_oe_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  assert_flow_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !rd_now) |=> (pipe_mode_i || !drive_o));

  assert_pipe_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !rd_now) ##1 pipe_mode_i |=> !drive_o);
endmodule

bind sram_datapath sram_datapath_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pipe_mode_i(pipe_mode_i),
  .sel_i      (sel_i),
  .gw_ni      (gw_ni),
  .bwe_ni     (bwe_ni),
  .be_ni      (be_ni),
  .oe_ni      (oe_ni),
  .drive_o    (drive_o)
);

// File: tb/tb_sram_datapath.sv
`timescale 1ns/1ps
module tb_sram_datapath;
  localparam int unsigned LW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 4 * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b1;
  logic          sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1;
  logic          bwe_n = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          drive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [1<<AW];

  always #2.5 clk = ~clk;

  sram_datapath #(.LANE_W(LW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pipe_mode_i(pipe_mode), .sel_i(sel),
    .addr_i(addr), .gw_ni(gw_n), .bwe_ni(bwe_n), .be_ni(be_n),
    .wdata_i(wdata), .oe_ni(oe_n), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s drive act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s data act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sel = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; be_n = 4'hF;
  endtask

  task automatic put_read(input logic [AW-1:0] a);
    sel = 1'b1; addr = a; gw_n = 1'b1; bwe_n = 1'b1; be_n = 4'hF;
  endtask

  // Reference update from the write rules
  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic g, input logic b, input logic [3:0] e);
    for (int i = 0; i < 4; i++) begin
      if (!g || (!b && !e[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
    end
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic g, input logic b, input logic [3:0] e);
    sel = 1'b1; addr = a; wdata = d; gw_n = g; bwe_n = b; be_n = e;
    model_write(a, d, g, b, e);
    step();
    idle();
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a);
    put_read(a);
    step();
    idle();
    if (pipe_mode) step(); else #1;
    chk_bit(req, drive, 1'b1);
    chk_word(req, rdata, model[a]);
  endtask

  task automatic t_reset();
    #1;
    chk_bit("R1", drive, 1'b0);
    step();
    rst_n = 1'b1;
    step(); step();
    chk_bit("R1", drive, 1'b0);
  endtask

  task automatic t_global_write();
    pipe_mode = 1'b1;
    write(4'd3, 32'hA1B2C3D4, 1'b0, 1'b0, 4'hF);
    read_chk("R4", 4'd3);
    write(4'd5, 32'h11223344, 1'b0, 1'b1, 4'h0);
    read_chk("R4", 4'd5);
  endtask

  task automatic t_byte_write();
    pipe_mode = 1'b0;
    write(4'd6, 32'hFFFFFFFF, 1'b0, 1'b1, 4'hF);
    write(4'd6, 32'h12345678, 1'b1, 1'b0, 4'b1010);
    read_chk("R5", 4'd6);
    chk_word("R5", model[6], 32'hFF34FF78);
    write(4'd6, 32'hAB000000, 1'b1, 1'b0, 4'b0111);
    read_chk("R5", 4'd6);
  endtask

  task automatic t_read_decode();
    pipe_mode = 1'b0;
    sel = 1'b1; addr = 4'd6; wdata = '0; gw_n = 1'b1; bwe_n = 1'b0; be_n = 4'hF;
    step(); idle(); #1;
    chk_bit("R6", drive, 1'b1);
    chk_word("R6", rdata, 32'hAB34FF78);
    sel = 1'b1; addr = 4'd6; wdata = '0; gw_n = 1'b1; bwe_n = 1'b1; be_n = 4'h0;
    step(); idle(); #1;
    chk_bit("R6", drive, 1'b1);
    read_chk("R6", 4'd6);
    chk_word("R6", rdata, 32'hAB34FF78);
  endtask

  task automatic t_flow_latency();
    pipe_mode = 1'b0;
    idle(); step();
    put_read(4'd5);
    step(); idle(); #1;
    chk_bit("R2", drive, 1'b1);
    chk_word("R2", rdata, model[5]);
  endtask

  task automatic t_pipe_latency();
    pipe_mode = 1'b1;
    idle(); step(); step();
    put_read(4'd5);
    step(); idle(); #1;
    chk_bit("R3", drive, 1'b0);
    step();
    chk_bit("R3", drive, 1'b1);
    chk_word("R3", rdata, model[5]);
  endtask

  task automatic t_burst();
    pipe_mode = 1'b1;
    for (int i = 0; i < 4; i++) write(AW'(8 + i), 32'hC0DE0000 + 32'(i * 17), 1'b0, 1'b1, 4'hF);
    step();
    for (int i = 0; i < 5; i++) begin
      if (i < 4) put_read(AW'(8 + i)); else idle();
      step();
      if (i == 0) chk_bit("R12", drive, 1'b0);
      else begin
        chk_bit("R12", drive, 1'b1);
        chk_word("R12", rdata, model[8 + i - 1]);
      end
    end
    idle();
  endtask

  task automatic t_write_hiz();
    pipe_mode = 1'b1;
    put_read(4'd5);
    step(); idle(); step();
    chk_bit("R7", drive, 1'b1);
    sel = 1'b1; addr = 4'd12; wdata = 32'h0BADF00D; gw_n = 1'b0;
    model_write(4'd12, 32'h0BADF00D, 1'b0, 1'b1, 4'hF);
    #1;
    chk_bit("R7", drive, 1'b0);
    step(); idle(); #1;
    chk_bit("R7", drive, 1'b0);
    step();
    chk_bit("R7", drive, 1'b0);
  endtask

  task automatic t_oe();
    pipe_mode = 1'b1;
    put_read(4'd5);
    step(); idle(); step();
    chk_bit("R8", drive, 1'b1);
    oe_n = 1'b1; #1;
    chk_bit("R8", drive, 1'b0);
    oe_n = 1'b0; #1;
    chk_bit("R8", drive, 1'b1);
    step();
    chk_bit("R8", drive, 1'b0);
  endtask

  task automatic t_dummy();
    pipe_mode = 1'b1;
    oe_n = 1'b1;
    put_read(4'd3);
    step(); idle(); step();
    chk_bit("R9", drive, 1'b0);
    oe_n = 1'b0; #1;
    chk_bit("R9", drive, 1'b1);
    chk_word("R9", rdata, model[3]);
    step();
  endtask

  task automatic t_raw();
    pipe_mode = 1'b0;
    sel = 1'b1; addr = 4'd7; wdata = 32'h5A5A0F0F; gw_n = 1'b0;
    model_write(4'd7, 32'h5A5A0F0F, 1'b0, 1'b1, 4'hF);
    step();
    read_chk("R10", 4'd7);
    pipe_mode = 1'b1;
    sel = 1'b1; addr = 4'd7; wdata = 32'h600DCAFE; gw_n = 1'b0;
    model_write(4'd7, 32'h600DCAFE, 1'b0, 1'b1, 4'hF);
    step();
    read_chk("R10", 4'd7);
    chk_word("R10", rdata, 32'h600DCAFE);
  endtask

  task automatic t_deselect();
    pipe_mode = 1'b1;
    put_read(4'd3);
    step();
    put_read(4'd5);
    step();
    idle(); #1;
    chk_word("R11", rdata, model[3]);
    step();
    chk_bit("R11", drive, 1'b1);
    chk_word("R11", rdata, model[5]);
    step();
    chk_bit("R11", drive, 1'b0);
    pipe_mode = 1'b0;
    put_read(4'd3);
    step(); idle(); #1;
    chk_bit("R11", drive, 1'b1);
    step();
    chk_bit("R11", drive, 1'b0);
  endtask

  initial begin
    t_reset();
    t_global_write();
    t_byte_write();
    t_read_decode();
    t_flow_latency();
    t_pipe_latency();
    t_burst();
    t_write_hiz();
    t_oe();
    t_dummy();
    t_raw();
    t_deselect();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule